// File: doc/BRIEF.md
# UTMI Byte-Pacing Data Path

This block is the parallel data path on the transceiver side of a UTMI-style link interface. It runs on the 60 MHz interface clock and shares one 8-bit bidirectional byte bus with the link. The three-state pad sits at chip level: the block reads the bus on `data_i` and drives it through `data_o` and `data_oe`. On the transmit side, the link raises `tx_valid` and holds a byte on the bus. The block takes one byte per byte time and hands it to an abstracted serial engine. On the receive side, the serial engine streams bytes in under packet framing. The block presents them to the link with `rx_active` framing and one `rx_valid` strobe per byte. Each received byte stays on the bus for the whole byte time.

`xcvr_hs` selects the pacing. At high speed, one byte time is one clock, so strobes can occur on consecutive clocks. At full speed, one byte time is `FS_BYTE_CLKS` clocks (40 by default, which gives 12 Mb/s at 60 MHz), and each strobe lasts a single clock. The serial-side transmit port follows valid/ready rules. A byte moves only on a cycle where `ser_tx_valid` and `ser_tx_ready` are both high. If `ser_tx_ready` is low when a byte time ends, the block defers the take until it rises and keeps its place in the byte time. The serial-side receive port also follows valid/ready rules. The block keeps at most one byte pending and lowers `ser_rx_ready` while that byte has not yet reached the link. Both serial ports pass bytes in strict order, never drop a byte, and never duplicate one.

Top module: `utmi_byte_pacer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_ready`, `rx_valid`, `rx_active` and `data_oe` are all 0.
- R2: At full speed (`xcvr_hs`=0), transmit starts on the clock after `tx_valid` is first seen in the idle state. `tx_ready` then pulses for a single clock on the 40th clock of transmit, and again every 40 clocks after each pulse.
- R3: At high speed (`xcvr_hs`=1), `tx_ready` is high on every transmit clock on which both `tx_valid` and `ser_tx_ready` are high, starting with the first transmit clock.
- R4: On every cycle where `tx_ready` is 1, `ser_tx_valid` is 1 and `ser_tx_data` equals the byte on the bus in that cycle. Bytes that the link places on the bus between strobes are not passed on.
- R5: If `ser_tx_ready` is 0 when a byte time ends, `tx_ready` stays 0 and pulses on the first later clock on which `ser_tx_ready` is 1. The next byte time is counted from that pulse.
- R6: When `tx_valid` is 0, `tx_ready` is 0 and transmit ends. A later `tx_valid` starts a new byte time from zero.
- R7: `ser_rx_active` seen in the idle state raises `rx_active` on the next clock, and wins over a `tx_valid` seen in the same cycle. `tx_ready` stays 0 while `rx_active` is 1.
- R8: At full speed, `rx_valid` pulses last one clock and start at least 40 clocks apart. When the serial side streams bytes without gaps, the pulses are exactly 40 clocks apart. At high speed with gapless input, they come on consecutive clocks.
- R9: While `rx_active` is 1, `data_o` changes only on a cycle where `rx_valid` is 1. It therefore holds each received byte until the next strobe.
- R10: `data_oe` is 1 exactly when `rx_active` is 1 and `tx_valid` is 0.
- R11: `rx_active` falls only after `ser_rx_active` has been 0 and every accepted byte has been strobed to the link.
- R12: `rx_valid` is only 1 while `rx_active` is 1. The bytes on `data_o` at the `rx_valid` strobes are the accepted serial bytes, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xcvr_hs | input | 1 | 1 = high-speed pacing, 0 = full-speed pacing |
| tx_valid | input | 1 | Link transmit request; also sets the bus direction |
| tx_ready | output | 1 | Strobe: the byte on the bus has been taken |
| data_i | input | 8 | Byte bus as read from the pad |
| data_o | output | 8 | Received byte driven toward the pad |
| data_oe | output | 1 | Pad output enable for the byte bus |
| rx_active | output | 1 | Receive packet framing toward the link |
| rx_valid | output | 1 | Strobe: a received byte is on the bus |
| ser_tx_valid | output | 1 | Transmit byte valid toward the serial engine |
| ser_tx_ready | input | 1 | Serial engine can take a transmit byte |
| ser_tx_data | output | 8 | Transmit byte toward the serial engine |
| ser_rx_active | input | 1 | Serial engine is inside a received packet |
| ser_rx_valid | input | 1 | Received byte valid from the serial engine |
| ser_rx_ready | output | 1 | Block can accept a received byte |
| ser_rx_data | input | 8 | Received byte from the serial engine |

## Verification
A new transmit request and the start of receive framing can arrive on the same idle cycle, so the two paths compete for the bus and the byte timer. The bench raises `tx_valid` and `ser_rx_active` together and keeps `tx_valid` high through the whole packet. It then expects `rx_active` on the next clock, no `tx_ready` during the packet, and the bus output disabled. Once the frame has closed, it expects a full-length transmit byte time counted from zero. Every cycle is compared against a bench-side model of the pacing, so a clock won by the wrong path, or a byte timer that does not restart, shows up in a named check.

// File: rtl/utmi_pacer_pkg.sv
package utmi_pacer_pkg;

  // Which path owns the shared byte timer and bus this cycle
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_TX   = 2'd1,
    PS_RX   = 2'd2
  } path_state_e;

endpackage

// File: rtl/utmi_byte_timer.sv
// Byte-time counter shared by both directions. Ticks on the last clock of a
// byte time; can be held on that clock while the consumer stalls.
module utmi_byte_timer #(
  parameter int FS_BYTE_CLKS = 40,
  localparam int CNT_W = (FS_BYTE_CLKS > 1) ? $clog2(FS_BYTE_CLKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hs_mode,
  input  logic hold,
  output logic tick
);

  localparam logic [CNT_W-1:0] FS_LAST = CNT_W'(FS_BYTE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = hs_mode ? '0 : FS_LAST;
  // >= keeps a mid-byte speed change from skipping the tick
  assign tick     = run && (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= hold ? cnt_q : '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/utmi_tx_pacer.sv
// Transmit side: takes the bus byte on a byte-time tick when the serial
// side is ready, and asks the timer to hold while it is not.
module utmi_tx_pacer #(
  parameter int DATA_W = 8
) (
  input  logic              active,
  input  logic              tick,
  input  logic              tx_valid,
  input  logic              ser_tx_ready,
  input  logic [DATA_W-1:0] bus_in,
  output logic              tx_ready,
  output logic              ser_tx_valid,
  output logic [DATA_W-1:0] ser_tx_data,
  output logic              stall
);

  logic take;

  assign take         = active && tick && tx_valid && ser_tx_ready;
  assign tx_ready     = take;
  assign ser_tx_valid = take;
  assign ser_tx_data  = bus_in;
  assign stall        = active && !(tx_valid && ser_tx_ready);

endmodule

// File: rtl/utmi_rx_pacer.sv
// Receive side: one pending byte from the serial side, moved to the bus
// register on a byte-time tick; the strobe follows the move by one clock.
module utmi_rx_pacer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              ser_rx_valid,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic              ser_rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              pending
);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] out_q;
  logic              full_q;
  logic              vld_q;
  logic              launch;
  logic              accept;

  assign launch       = active && tick && full_q;
  assign ser_rx_ready = active && (!full_q || launch);
  assign accept       = ser_rx_valid && ser_rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      vld_q  <= 1'b0;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      vld_q <= launch;
      if (launch) begin
        out_q <= hold_q;
      end
      if (accept) begin
        hold_q <= ser_rx_data;
        full_q <= 1'b1;
      end else if (launch) begin
        full_q <= 1'b0;
      end
    end
  end

  assign rx_valid = vld_q;
  assign rx_byte  = out_q;
  assign pending  = full_q;

endmodule

// File: rtl/utmi_byte_pacer.sv
module utmi_byte_pacer
  import utmi_pacer_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int FS_BYTE_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xcvr_hs,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              rx_active,
  output logic              rx_valid,
  output logic              ser_tx_valid,
  input  logic              ser_tx_ready,
  output logic [DATA_W-1:0] ser_tx_data,
  input  logic              ser_rx_active,
  input  logic              ser_rx_valid,
  output logic              ser_rx_ready,
  input  logic [DATA_W-1:0] ser_rx_data
);

  path_state_e state_q, state_d;
  logic        tick;
  logic        tx_stall;
  logic        rx_pending;
  logic        in_tx;
  logic        in_rx;

  assign in_tx = (state_q == PS_TX);
  assign in_rx = (state_q == PS_RX);

  // Receive framing has priority over a new transmit request
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: begin
        if (ser_rx_active)  state_d = PS_RX;
        else if (tx_valid)  state_d = PS_TX;
      end
      PS_TX: begin
        if (!tx_valid)      state_d = PS_IDLE;
      end
      PS_RX: begin
        if (!ser_rx_active && !rx_pending) state_d = PS_IDLE;
      end
      default:              state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  utmi_byte_timer #(
    .FS_BYTE_CLKS (FS_BYTE_CLKS)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_tx || in_rx),
    .hs_mode (xcvr_hs),
    .hold    (tx_stall),
    .tick    (tick)
  );

  utmi_tx_pacer #(
    .DATA_W (DATA_W)
  ) i_tx (
    .active       (in_tx),
    .tick         (tick),
    .tx_valid     (tx_valid),
    .ser_tx_ready (ser_tx_ready),
    .bus_in       (data_i),
    .tx_ready     (tx_ready),
    .ser_tx_valid (ser_tx_valid),
    .ser_tx_data  (ser_tx_data),
    .stall        (tx_stall)
  );

  utmi_rx_pacer #(
    .DATA_W (DATA_W)
  ) i_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (in_rx),
    .tick         (tick),
    .ser_rx_valid (ser_rx_valid),
    .ser_rx_data  (ser_rx_data),
    .ser_rx_ready (ser_rx_ready),
    .rx_valid     (rx_valid),
    .rx_byte      (data_o),
    .pending      (rx_pending)
  );

  assign rx_active = in_rx;
  assign data_oe   = in_rx && !tx_valid;

endmodule

// File: rtl/utmi_pacer_chk.sv
module utmi_pacer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xcvr_hs,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe,
  input logic              rx_active,
  input logic              rx_valid,
  input logic              ser_rx_active
);

  // R2
  tx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xcvr_hs && tx_ready) |=> !tx_ready);

  // R7
  tx_blocked_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !tx_ready);

  // R8
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xcvr_hs && rx_valid) |=> !rx_valid);

  // R9
  rx_byte_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && !rx_valid) |-> $stable(data_o));

  // R10
  bus_released_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !data_oe);

  // R11
  rx_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> ($past(ser_rx_active) == 1'b0));

  // R12
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);

endmodule

bind utmi_byte_pacer utmi_pacer_chk #(
  .DATA_W (DATA_W)
) i_pacer_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xcvr_hs       (xcvr_hs),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .data_o        (data_o),
  .data_oe       (data_oe),
  .rx_active     (rx_active),
  .rx_valid      (rx_valid),
  .ser_rx_active (ser_rx_active)
);

// File: tb/test_utmi_byte_pacer.sv
module test_utmi_byte_pacer;

  localparam int FS_CLKS = 40;
  localparam int M_IDLE = 0;
  localparam int M_TX   = 1;
  localparam int M_RX   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       xcvr_hs = 1'b0;
  logic       tx_valid = 1'b0;
  logic       ser_tx_ready = 1'b1;
  logic       ser_rx_active = 1'b0;
  logic       ser_rx_valid = 1'b0;
  logic [7:0] link_byte = 8'h00;
  logic [7:0] ser_rx_data = 8'h00;

  wire [7:0] data_i, data_o, ser_tx_data;
  wire       tx_ready, data_oe, rx_active, rx_valid, ser_tx_valid, ser_rx_ready;

  // pad model: link drives while transmitting, else the block if enabled
  assign data_i = tx_valid ? link_byte : (data_oe ? data_o : 8'h00);

  utmi_byte_pacer i_utmi_byte_pacer (
    .clk           (clk),
    .rst_n         (rst_n),
    .xcvr_hs       (xcvr_hs),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .data_i        (data_i),
    .data_o        (data_o),
    .data_oe       (data_oe),
    .rx_active     (rx_active),
    .rx_valid      (rx_valid),
    .ser_tx_valid  (ser_tx_valid),
    .ser_tx_ready  (ser_tx_ready),
    .ser_tx_data   (ser_tx_data),
    .ser_rx_active (ser_rx_active),
    .ser_rx_valid  (ser_rx_valid),
    .ser_rx_ready  (ser_rx_ready),
    .ser_rx_data   (ser_rx_data)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // model and scoreboard state
  int         m_st = M_IDLE;
  int         m_el = 0;
  bit         m_new_rx = 1'b0;
  int         per;
  bit         exp_tx;
  int         taken = 0;
  logic [7:0] sent [64];
  int         ns = 0;
  int         rcv = 0;
  int         cyc = 0;
  int         first_p = 0;
  int         last_p = 0;
  logic [7:0] last_b = 8'h00;
  bit         have_last = 1'b0;
  bit         post_rst = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int byte_time(input bit hs);
    return hs ? 1 : FS_CLKS;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(!tx_ready && !rx_valid && !rx_active && !data_oe, "R1",
          "outputs in reset", {tx_ready, rx_valid, rx_active, data_oe}, 0);
      m_st = M_IDLE;
      m_el = 0;
      post_rst = 1'b1;
    end else begin
      per = byte_time(xcvr_hs);
      if (post_rst) begin
        chk(!tx_ready && !rx_valid && !rx_active && !data_oe, "R1",
            "outputs after reset", {tx_ready, rx_valid, rx_active, data_oe}, 0);
        post_rst = 1'b0;
      end
      if (m_st == M_RX) begin
        if (m_new_rx) begin
          chk(rx_active, "R7", "rx_active after framing start", int'(rx_active), 1);
          m_new_rx = 1'b0;
        end else if (!rx_active) begin
          chk(rcv == ns, "R11", "bytes strobed at frame end", rcv, ns);
          chk(!ser_rx_active, "R11", "serial framing at frame end", int'(ser_rx_active), 0);
          m_st = M_IDLE;
        end
      end else begin
        chk(!rx_active, "R7", "rx_active outside receive", int'(rx_active), 0);
      end
      chk(data_oe == (rx_active && !tx_valid), "R10", "bus enable",
          int'(data_oe), int'(rx_active && !tx_valid));
      exp_tx = (m_st == M_TX) && tx_valid && ser_tx_ready && (m_el >= per - 1);
      if (xcvr_hs) chk(tx_ready == exp_tx, "R3", "tx_ready", int'(tx_ready), int'(exp_tx));
      else         chk(tx_ready == exp_tx, "R2", "tx_ready", int'(tx_ready), int'(exp_tx));
      if (tx_ready) begin
        chk(ser_tx_valid && (ser_tx_data == link_byte), "R4", "taken byte",
            int'(ser_tx_data), int'(link_byte));
        taken++;
      end
      if (rx_valid) begin
        chk(rcv < ns && data_o == sent[rcv[5:0]], "R12", "strobed byte",
            int'(data_o), (rcv < ns) ? int'(sent[rcv[5:0]]) : -1);
        if (!xcvr_hs && have_last)
          chk(cyc - last_p >= FS_CLKS, "R8", "full-speed strobe spacing",
              cyc - last_p, FS_CLKS);
        if (!have_last) first_p = cyc;
        last_p = cyc;
        last_b = data_o;
        have_last = 1'b1;
        rcv++;
      end else if (rx_active && have_last) begin
        chk(data_o == last_b, "R9", "byte held between strobes",
            int'(data_o), int'(last_b));
      end
      // advance the model to the next cycle
      case (m_st)
        M_IDLE: begin
          if (ser_rx_active) begin
            m_st = M_RX;
            m_new_rx = 1'b1;
          end else if (tx_valid) begin
            m_st = M_TX;
            m_el = 0;
          end
        end
        M_TX: begin
          if (!tx_valid)          m_st = M_IDLE;
          else if (exp_tx)        m_el = 0;
          else if (m_el < per - 1) m_el++;
        end
        default: ;
      endcase
    end
  end

  task automatic tx_burst(input int n, input int stall_pct);
    int start;
    start = taken;
    tx_valid = 1'b1;
    link_byte = 8'($urandom);
    ser_tx_ready = (($urandom % 100) >= stall_pct);
    while (taken - start < n) begin
      @(posedge clk); #1;
      if ($urandom % 2 == 1) link_byte = 8'($urandom);
      ser_tx_ready = (($urandom % 100) >= stall_pct);
    end
    tx_valid = 1'b0;
    ser_tx_ready = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic rx_packet(input int n, input int gap_pct);
    bit acc;
    ns = 0;
    rcv = 0;
    have_last = 1'b0;
    ser_rx_active = 1'b1;
    for (int i = 0; i < n; i++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        ser_rx_valid = 1'b0;
        @(posedge clk); #1;
      end
      ser_rx_valid = 1'b1;
      ser_rx_data = 8'($urandom);
      do begin
        @(negedge clk);
        acc = ser_rx_ready;
        @(posedge clk); #1;
      end while (!acc);
      sent[ns[5:0]] = ser_rx_data;
      ns++;
    end
    ser_rx_valid = 1'b0;
    ser_rx_active = 1'b0;
    do @(negedge clk); while (rx_active);
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R2: full-speed transmit, serial side always ready
    xcvr_hs = 1'b0;
    tx_burst(3, 0);
    // R5: full-speed transmit with serial back-pressure
    tx_burst(3, 40);
    // R3: high-speed transmit, then with back-pressure (R5)
    xcvr_hs = 1'b1;
    tx_burst(20, 0);
    tx_burst(20, 50);
    // R6: full-speed request dropped before a byte time ends, then restart
    xcvr_hs = 1'b0;
    tx_valid = 1'b1;
    link_byte = 8'h5A;
    repeat (25) @(posedge clk);
    #1 tx_valid = 1'b0;
    repeat (3) @(posedge clk); #1;
    tx_burst(1, 0);

    // R8: gapless full-speed receive, strobes exactly one byte time apart
    rx_packet(5, 0);
    chk(last_p - first_p == 4 * FS_CLKS, "R8", "full-speed stream span",
        last_p - first_p, 4 * FS_CLKS);
    chk(rcv == 5, "R12", "full-speed byte count", rcv, 5);
    // R8: gapless high-speed receive, back-to-back strobes
    xcvr_hs = 1'b1;
    rx_packet(8, 0);
    chk(last_p - first_p == 7, "R8", "high-speed stream span", last_p - first_p, 7);

    // R7: transmit request and receive framing start in the same cycle
    xcvr_hs = 1'b0;
    tx_valid = 1'b1;
    link_byte = 8'hC3;
    rx_packet(2, 0);
    chk(rcv == 2, "R7", "receive won the collision", rcv, 2);
    tx_burst(2, 0);

    // mixed random traffic
    for (int it = 0; it < 14; it++) begin
      xcvr_hs = $urandom % 2;
      if ($urandom % 2 == 1)
        tx_burst(xcvr_hs ? 1 + int'($urandom % 25) : 1 + int'($urandom % 3),
                 int'($urandom % 50));
      else
        rx_packet(1 + int'($urandom % 6), int'($urandom % 40));
      repeat (int'($urandom % 4)) @(posedge clk);
      #1;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule